// File: doc/BRIEF.md
# Segmented DAC Digital Front End

This block sits in front of a segmented current-steering converter and turns each 8-bit binary sample into the 12 switch controls that the analog array needs. The three most significant bits are decoded into a 7-bit thermometer word, one bit per unit current cell. The five least significant bits are not decoded and go on to drive a binary-weighted array.

Two edge-triggered register stages carry the sample through the block. The first stage holds the raw 8-bit input. The second stage holds the decoded thermometer bits and the raw low bits side by side. All 12 controls therefore change on one clock edge, and no decoder settling time reaches the switches. A check output rebuilds the unit-weighted level from the registered controls. A test environment can compare that level with the code that was applied.

Top module: `dacfe_seg_front`

## Requirements
- R1: The sample is split with bits [7:5] forming the upper segment and bits [4:0] forming the lower segment.
- R2: An upper-segment value k (0 to 7) drives exactly the k lowest bits of `therm_o` high and every other bit low: 0 gives 7'b0000000 and 7 gives 7'b1111111.
- R3: `bin_o` equals bits [4:0] of the sample, unchanged.
- R4: A sample on `din_i` at rising edge n appears on the outputs after rising edge n+1, a latency of two registers.
- R5: In every cycle, `therm_o` and `bin_o` belong to the same sample, so both change on the same edge.
- R6: While `rst_n` is low at a rising edge, both stages clear, and the following cycle shows zero on `therm_o`, `bin_o` and `level_o`.
- R7: `level_o` equals 32 times the number of set bits in `therm_o`, plus `bin_o`. This is the sample code that the outputs carry.
- R8: `therm_o` never holds a set bit above a cleared bit. Over a rising input sweep, its count of set bits never falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Conversion clock; both stages update on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| din_i | input | 8 | Binary sample code |
| therm_o | output | 7 | Unit-cell switch controls, thermometer coded |
| bin_o | output | 5 | Binary-array switch controls |
| level_o | output | 8 | Unit-weighted level rebuilt from the registered controls |

## Verification
An ascending sweep of all 256 codes exercises every thermometer value. It also exercises each carry across the 31/32 boundaries, where the lower segment wraps while the upper one steps, and it shows any count that falls or any bubble. A descending sweep follows, and after it a pseudo-random sequence and an alternation between 0 and 255. These patterns change every bit from one cycle to the next. A wrong delay or a mismatch between the two halves then shows as a wrong level, which a slowly moving input can hide. A reset asserted in the middle of a run, with a nonzero code held on the input, shows that both stages clear and that refilling takes two edges.

// File: rtl/dacfe_pkg.sv
// Shared sizing for the segmented converter front end.
// Assumes the upper segment is narrow enough that its thermometer decode is small.
package dacfe_pkg;
    localparam int MSB_W   = 3;
    localparam int LSB_W   = 5;
    localparam int IN_W    = MSB_W + LSB_W;
    localparam int THERM_W = (1 << MSB_W) - 1;
    localparam int OUT_W   = THERM_W + LSB_W;
endpackage

// File: rtl/dacfe_stage.sv
// Pipeline stage: a W-bit register with synchronous active-low clear.
// Assumes one clock domain; the data input is stable around the rising edge.
module dacfe_stage #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    // Capture the data on each rising edge, or clear it in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) q_o <= '0;
        else        q_o <= d_i;
    end
endmodule

// File: rtl/dacfe_therm_dec.sv
// Binary-to-thermometer decoder. A one-hot row decode feeds a NOR array:
// output bit j is high when no row 0..j is selected, which means the value exceeds j.
// Assumes a purely combinational path; the next stage registers the result.
module dacfe_therm_dec #(
    parameter  int SEL_W = 3,
    localparam int ROWS  = 1 << SEL_W,
    localparam int TW    = ROWS - 1
) (
    input  logic [SEL_W-1:0] sel_i,
    output logic [TW-1:0]    therm_o
);
    logic [ROWS-1:0] row;

    // One-hot row select for the binary value.
    always_comb begin
        row        = '0;
        row[sel_i] = 1'b1;
    end

    // NOR combining array: one column for each unit cell.
    for (genvar j = 0; j < TW; j++) begin : g_col
        assign therm_o[j] = ~(|row[j:0]);
    end
endmodule

// File: rtl/dacfe_seg_front.sv
// Segmented converter front end. Stage one holds the raw sample. The upper
// segment is then thermometer decoded. Stage two holds {thermometer, lower bits},
// so all switch controls change together. level_o rebuilds the unit-weighted code.
// Assumes a synchronous active-low reset that is held for at least one edge.
module dacfe_seg_front #(
    parameter  int MSB_W   = dacfe_pkg::MSB_W,
    parameter  int LSB_W   = dacfe_pkg::LSB_W,
    localparam int IN_W    = MSB_W + LSB_W,
    localparam int THERM_W = (1 << MSB_W) - 1,
    localparam int OUT_W   = THERM_W + LSB_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [IN_W-1:0]    din_i,
    output logic [THERM_W-1:0] therm_o,
    output logic [LSB_W-1:0]   bin_o,
    output logic [IN_W-1:0]    level_o
);
    logic [IN_W-1:0]    mst_q;
    logic [THERM_W-1:0] therm_d;
    logic [OUT_W-1:0]   slv_q;
    logic [IN_W-1:0]    cnt;

    dacfe_stage #(.W(IN_W)) u_master (
        .clk(clk), .rst_n(rst_n), .d_i(din_i), .q_o(mst_q)
    );

    dacfe_therm_dec #(.SEL_W(MSB_W)) u_dec (
        .sel_i(mst_q[IN_W-1:LSB_W]), .therm_o(therm_d)
    );

    dacfe_stage #(.W(OUT_W)) u_slave (
        .clk(clk), .rst_n(rst_n), .d_i({therm_d, mst_q[LSB_W-1:0]}), .q_o(slv_q)
    );

    assign therm_o = slv_q[OUT_W-1:LSB_W];
    assign bin_o   = slv_q[LSB_W-1:0];

    // Rebuild the unit-weighted level from the registered controls.
    always_comb begin
        cnt = '0;
        for (int i = 0; i < THERM_W; i++) cnt = cnt + IN_W'(therm_o[i]);
        level_o = IN_W'(cnt << LSB_W) | IN_W'(bin_o);
    end

    // Stage one carries the sample seen at the previous edge.
    p_master_capture_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> mst_q == $past(din_i));

    // The count of set thermometer bits equals the upper segment of the held sample.
    p_therm_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $countones(therm_o) == $past(32'(mst_q[IN_W-1:LSB_W])));

    // The lower bits reach the binary controls unchanged.
    p_lsb_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> bin_o == $past(mst_q[LSB_W-1:0]));

    // Two registers from input to output.
    p_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2)) |-> level_o == $past(din_i, 2));

    // The rebuilt level matches the sample held in stage one one cycle earlier.
    p_level_match_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> level_o == $past(mst_q));

    // No bubble: the set bits form one run starting at bit 0.
    p_no_bubble_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (THERM_W'(therm_o + 1'b1) & therm_o) == '0);
endmodule

// File: tb/sim_dacfe_seg_front.sv
module sim_dacfe_seg_front;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] din = 8'd0;
    logic [6:0] therm;
    logic [4:0] bin;
    logic [7:0] level;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // Behavioural model: a history of the codes seen at each rising edge.
    int hist[$];

    dacfe_seg_front u0 (
        .clk(clk), .rst_n(rst_n), .din_i(din),
        .therm_o(therm), .bin_o(bin), .level_o(level)
    );

    always #2 clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) hist = '{0, 0};
        else begin
            hist.push_back(int'(din));
            if (hist.size() > 2) void'(hist.pop_front());
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Compare every output against the code two edges back (R4).
    task automatic cmp_all();
        int code, k;
        code = hist[0];
        k = code >> 5;
        chk("R1_upper_field", $countones(therm), k);
        chk("R2_therm", int'(therm), (1 << k) - 1);
        chk("R3_bin", int'(bin), code & 31);
        chk("R4_R5_R7_level", int'(level), code);
    endtask

    task automatic step(input int v);
        @(negedge clk);
        cmp_all();
        din = 8'(v);
    endtask

    initial begin
        int prev_cnt;
        int lfsr;
        repeat (3) @(negedge clk);
        chk("R6_therm_reset", int'(therm), 0);
        chk("R6_bin_reset", int'(bin), 0);
        chk("R6_level_reset", int'(level), 0);
        rst_n = 1'b1;

        // Ascending sweep, with a monotonicity check (R8).
        prev_cnt = 0;
        for (int v = 0; v < 256; v++) begin
            step(v);
            if ($countones(therm) < prev_cnt)
                chk("R8_monotonic", $countones(therm), prev_cnt);
            prev_cnt = $countones(therm);
        end
        for (int v = 255; v >= 0; v--) step(v);

        // Boundaries of the lower segment.
        step(31); step(32); step(223); step(224); step(0); step(255);

        // Pseudo-random sequence.
        lfsr = 8'hA5;
        for (int i = 0; i < 200; i++) begin
            lfsr = ((lfsr * 37) + 11) & 255;
            step(lfsr);
        end
        for (int i = 0; i < 20; i++) step((i & 1) ? 255 : 0);

        // Reset in mid-run with a nonzero input held (R6).
        step(200); step(201);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R6_mid_therm", int'(therm), 0);
        chk("R6_mid_bin", int'(bin), 0);
        chk("R6_mid_level", int'(level), 0);
        rst_n = 1'b1;
        din = 8'd77;
        @(negedge clk);
        chk("R4_refill_gap", int'(level), 0);
        din = 8'd150;
        @(negedge clk);
        chk("R4_refill_first", int'(level), 77);
        @(negedge clk);
        chk("R4_refill_second", int'(level), 150);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                #(4 * 150000);
                n_chk++;
                n_fail++;
                $display("FAIL watchdog actual=hung expected=done");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule